// File: doc/BRIEF.md
# Core Power State Debug Gate

This block follows the power state of a single processor core and decides what happens to external debug traffic in each state. The core can be running normally, idling in standby after a wait-for-interrupt or wait-for-event hint, held in retention with its state kept, or fully powered down. Debug requests and debug register accesses are serviced, used to wake the core, or held and refused, depending on that state.

The block sits in an always-on domain next to the external debug logic. This means its status output stays readable while the core domain is off. The power controller and the save and restore software appear only as handshakes: a power-good input, a restore-done input, and a cold-reset output. Leaving powerdown goes through four steps in order: power returns, a cold reset of fixed length is applied, restore is acknowledged, and normal running resumes.

Top module: `core_pwr_dbg_gate`

## Requirements
- R1: After reset, `pwr_status_o` is 2'b00, and `dbg_pend_o`, `dbg_req_o`, `wake_o` and `cold_rst_o` are all low.
- R2: In normal, a `wfx_i` pulse moves the core to standby. In standby, `wake_evt_i` returns it to normal, after which an access is granted in its first cycle.
- R3: In standby, `dbg_req_i` or `acc_valid_i` raises `wake_o` in that same cycle and the core is normal from the next cycle. An access in standby is held (`acc_ready_o` low) for that one cycle and is granted in the next. A debug request that arrives in standby comes out on `dbg_req_o` in the following cycle.
- R4: `pwr_status_o` reads 2'b00 in both normal and standby, so the two states cannot be told apart.
- R5: In retention, `pwr_status_o` is 2'b01. A `dbg_req_i` sets `dbg_pend_o`, which stays set, and `dbg_req_o` stays low.
- R6: In retention, `restore_done_i` returns the core to normal in the next cycle, and `cold_rst_o` is never raised on that exit.
- R7: In powerdown and throughout its exit, `pwr_status_o` is 2'b10. Debug requests set `dbg_pend_o`, and accesses are refused.
- R8: Powerdown is left only on a rising edge of `pwr_good_i`. From the next cycle, `cold_rst_o` is high for exactly RST_CYCLES cycles. The block then waits for `restore_done_i`, and normal follows in the next cycle.
- R9: If `pwr_good_i` falls during the cold reset or the restore wait, the block goes back to waiting for power: `cold_rst_o` drops, and a new rising edge starts a full-length cold reset.
- R10: A pending debug request is driven as a one-cycle `dbg_req_o` pulse in the first normal cycle, and `dbg_pend_o` is low in the following cycle.
- R11: An access (`acc_valid_i` held high until it is answered) is answered with `acc_ready_o` for one cycle. The answer carries `acc_err_o`=0 in normal and `acc_err_o`=1 in retention or powerdown.
- R12: Retention and powerdown requests are taken only in normal or standby. If both arrive in the same cycle, powerdown wins. A powerdown request made in retention has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfx_i | input | 1 | Wait-for-interrupt or wait-for-event hint |
| wake_evt_i | input | 1 | Wake-up event for standby |
| ret_req_i | input | 1 | Retention request from the OS |
| pd_req_i | input | 1 | Powerdown request from the OS |
| pwr_good_i | input | 1 | Core domain power is good |
| restore_done_i | input | 1 | Saved core state has been restored |
| dbg_req_i | input | 1 | External debug request pulse |
| acc_valid_i | input | 1 | Debug register access request |
| acc_ready_o | output | 1 | Access answered this cycle |
| acc_err_o | output | 1 | Access refused (valid together with ready) |
| dbg_pend_o | output | 1 | A debug request is being held |
| dbg_req_o | output | 1 | Debug request delivered to the core |
| wake_o | output | 1 | Debug traffic is waking the core from standby |
| cold_rst_o | output | 1 | Cold reset to the core |
| pwr_status_o | output | 2 | 00 up, 01 retention, 10 powered off |

## Verification
The bench builds the block with RST_CYCLES set to 3. With that value, each cycle of the cold-reset window can be checked individually, in a powerdown exit and again after a power loss partway through reset. The short window also puts the loss-and-retry path, the pending-request delivery and both access answers within a few dozen cycles of each scenario.

// File: rtl/core_pwr_dbg_gate.sv
module core_pwr_dbg_gate #(
  parameter int RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wfx_i,
  input  logic       wake_evt_i,
  input  logic       ret_req_i,
  input  logic       pd_req_i,
  input  logic       pwr_good_i,
  input  logic       restore_done_i,
  input  logic       dbg_req_i,
  input  logic       acc_valid_i,
  output logic       acc_ready_o,
  output logic       acc_err_o,
  output logic       dbg_pend_o,
  output logic       dbg_req_o,
  output logic       wake_o,
  output logic       cold_rst_o,
  output logic [1:0] pwr_status_o
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

  typedef enum logic [2:0] {S_RUN, S_IDLE, S_KEEP, S_OFF, S_CRST, S_REST} st_t;

  st_t             st, st_nx;
  logic [CNT_W-1:0] cnt;
  logic            pg_q, pend;

  wire up      = (st == S_RUN) || (st == S_IDLE);
  wire dbg_act = dbg_req_i || acc_valid_i;

  always_comb begin
    st_nx = st;
    case (st)
      S_RUN:  if (pd_req_i) st_nx = S_OFF;
              else if (ret_req_i) st_nx = S_KEEP;
              else if (wfx_i) st_nx = S_IDLE;
      S_IDLE: if (pd_req_i) st_nx = S_OFF;
              else if (ret_req_i) st_nx = S_KEEP;
              else if (wake_evt_i || dbg_act) st_nx = S_RUN;
      S_KEEP: if (restore_done_i) st_nx = S_RUN;
      S_OFF:  if (pwr_good_i && !pg_q) st_nx = S_CRST;
      S_CRST: if (!pwr_good_i) st_nx = S_OFF;
              else if (cnt == CNT_LAST) st_nx = S_REST;
      S_REST: if (!pwr_good_i) st_nx = S_OFF;
              else if (restore_done_i) st_nx = S_RUN;
      default: st_nx = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_RUN;
      cnt  <= '0;
      pg_q <= 1'b0;
      pend <= 1'b0;
    end else begin
      st   <= st_nx;
      pg_q <= pwr_good_i;
      cnt  <= (st == S_CRST) ? cnt + 1'b1 : '0;
      if (st == S_RUN) pend <= 1'b0;
      else if (dbg_req_i) pend <= 1'b1;
    end
  end

  assign acc_ready_o  = acc_valid_i && (st != S_IDLE);
  assign acc_err_o    = acc_valid_i && !up;
  assign dbg_pend_o   = pend;
  assign dbg_req_o    = (st == S_RUN) && (pend || dbg_req_i);
  assign wake_o       = (st == S_IDLE) && dbg_act && !pd_req_i && !ret_req_i;
  assign cold_rst_o   = (st == S_CRST);
  assign pwr_status_o = up ? 2'b00 : (st == S_KEEP) ? 2'b01 : 2'b10;

  logic [CNT_W:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else        run_len <= cold_rst_o ? run_len + 1'b1 : '0;
  end

  p_rst_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_REST && $past(st) == S_CRST) |-> run_len == (CNT_W+1)'(RST_CYCLES));
  p_pd_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_req_i && ret_req_i && pwr_status_o == 2'b00) |=> pwr_status_o == 2'b10);
  p_ret_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_status_o == 2'b01 && !restore_done_i) |=> pwr_status_o == 2'b01);
  p_pend_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_pend_o && pwr_status_o != 2'b00) |=> dbg_pend_o);
  p_deliver_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req_o |=> !dbg_pend_o);
  p_no_grant_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ready_o && !acc_err_o) |-> pwr_status_o == 2'b00);
  p_ret_exit_warm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_status_o) == 2'b01 && pwr_status_o == 2'b00) |-> !cold_rst_o);
endmodule

// File: tb/tb_core_pwr_dbg_gate.sv
`timescale 1ns/1ps
module tb_core_pwr_dbg_gate;
  localparam int RST_CYCLES = 3;
  logic clk = 0, rst_n = 0;
  logic wfx = 0, wake = 0, ret = 0, pd = 0, pg = 1, rdone = 0, dreq = 0, acc = 0;
  logic acc_ready, acc_err, pend, dreq_o, wake_o, cold;
  logic [1:0] status;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  core_pwr_dbg_gate #(.RST_CYCLES(RST_CYCLES)) dut (
    .clk(clk), .rst_n(rst_n), .wfx_i(wfx), .wake_evt_i(wake), .ret_req_i(ret),
    .pd_req_i(pd), .pwr_good_i(pg), .restore_done_i(rdone), .dbg_req_i(dreq),
    .acc_valid_i(acc), .acc_ready_o(acc_ready), .acc_err_o(acc_err),
    .dbg_pend_o(pend), .dbg_req_o(dreq_o), .wake_o(wake_o), .cold_rst_o(cold),
    .pwr_status_o(status));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nx; @(negedge clk); #1; endtask

  task automatic t_reset;
    chk("R1 status", status, 0); chk("R1 pend", pend, 0);
    chk("R1 dbg_req", dreq_o, 0); chk("R1 wake", wake_o, 0); chk("R1 cold", cold, 0);
  endtask

  task automatic t_normal_access;
    acc = 1; #1;
    chk("R11 grant ready", acc_ready, 1); chk("R11 grant err", acc_err, 0);
    nx(); acc = 0;
  endtask

  task automatic t_standby;
    wfx = 1; nx(); wfx = 0;
    chk("R4 standby status", status, 0);
    acc = 1; #1;
    chk("R3 standby holds access", acc_ready, 0); chk("R3 wake", wake_o, 1);
    nx();
    chk("R3 access after wake", acc_ready, 1); chk("R3 access err", acc_err, 0);
    acc = 0;
    wfx = 1; nx(); wfx = 0;
    wake = 1; nx(); wake = 0;
    acc = 1; #1;
    chk("R2 access after wake event", acc_ready, 1);
    nx(); acc = 0;
    wfx = 1; nx(); wfx = 0;
    dreq = 1; #1;
    chk("R3 dbg wake", wake_o, 1); chk("R3 no delivery in standby", dreq_o, 0);
    nx(); dreq = 0; #1;
    chk("R3 delivered after wake", dreq_o, 1);
    nx();
    chk("R10 pulse one cycle", dreq_o, 0); chk("R10 pend cleared", pend, 0);
  endtask

  task automatic t_retention;
    ret = 1; nx(); ret = 0;
    chk("R5 status", status, 1);
    dreq = 1; nx(); dreq = 0; #1;
    chk("R5 pend", pend, 1); chk("R5 no delivery", dreq_o, 0);
    acc = 1; #1;
    chk("R11 refused ready", acc_ready, 1); chk("R11 refused err", acc_err, 1);
    nx(); acc = 0;
    pd = 1; nx(); pd = 0;
    chk("R12 pd ignored in retention", status, 1); chk("R5 pend kept", pend, 1);
    rdone = 1; nx(); rdone = 0; #1;
    chk("R6 status normal", status, 0); chk("R6 no cold reset", cold, 0);
    chk("R10 delivered", dreq_o, 1);
    nx();
    chk("R10 pulse ends", dreq_o, 0); chk("R10 pend cleared", pend, 0);
  endtask

  task automatic rst_window(string req);
    for (int i = 0; i < RST_CYCLES; i++) begin
      chk(req, cold, 1); chk("R7 status off", status, 2); nx();
    end
    chk(req, cold, 0);
  endtask

  task automatic t_powerdown;
    pd = 1; ret = 1; nx(); pd = 0; ret = 0;
    chk("R12 pd wins", status, 2);
    dreq = 1; nx(); dreq = 0; #1;
    chk("R7 pend", pend, 1); chk("R7 no delivery", dreq_o, 0);
    acc = 1; #1;
    chk("R7 refused", acc_err, 1); chk("R11 answered", acc_ready, 1);
    nx(); acc = 0;
    nx(); chk("R8 no reset without power edge", cold, 0);
    pg = 0; nx(); nx(); chk("R8 waits power", cold, 0);
    pg = 1; nx();
    rst_window("R8 cold window");
    chk("R8 restore wait status", status, 2); chk("R8 no delivery yet", dreq_o, 0);
    rdone = 1; nx(); rdone = 0; #1;
    chk("R8 normal after restore", status, 0); chk("R10 delivered", dreq_o, 1);
    nx(); chk("R10 pend cleared", pend, 0);
  endtask

  task automatic t_power_loss;
    pd = 1; nx(); pd = 0;
    pg = 0; nx(); pg = 1; nx();
    chk("R9 cold starts", cold, 1);
    pg = 0; nx();
    chk("R9 cold dropped", cold, 0); chk("R9 still off", status, 2);
    nx(); chk("R9 waits", cold, 0);
    pg = 1; nx();
    rst_window("R9 full window again");
    pg = 0; nx(); chk("R9 loss in restore wait", status, 2);
    pg = 1; nx();
    rst_window("R9 window after restore-wait loss");
    rdone = 1; nx(); rdone = 0;
    chk("R9 normal", status, 0);
  endtask

  initial begin
    #9 rst_n = 1; nx();
    t_reset(); t_normal_access(); t_standby(); t_retention();
    t_powerdown(); t_power_loss();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule